// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one bus machine cycle at a time on an external bus where the low address byte and the data byte share the same eight lines. A client presents a cycle kind, a 16-bit address and a write byte. The sequencer steps through T-states and drives the following signals:

- the high address byte;
- the shared lines with their output enable;
- an address strobe during the first T-state;
- active-low read and write strobes;
- a memory/I/O select;
- a two-bit status code that names the cycle kind.

For read-type cycles it captures the byte on the shared lines and reports it with a one-cycle completion pulse.

Slow targets stretch a cycle by holding the ready input low, which inserts wait states between T2 and T3. Another bus master can ask for the bus with a hold request. The request is granted only after the cycle in flight has finished. The sequencer then raises its acknowledge and releases every output except the address strobe. When the request is withdrawn it takes the bus back. Instruction decode and the number of machine cycles per instruction belong to the client.

Top module: `bus_seq_top`

## Requirements
- R1: After reset the sequencer is idle: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `hlda`=0, `done`=0, `bus_oe`=1, status {`s1`,`s0`}=00, `io_m`=0 and `req_ready`=1.
- R2: A request is taken at a clock edge when the sequencer is idle, `hold` is low, `req_valid` is high and `req_kind` is legal. The next clock cycle is T1. In T1 `ale` is 1, `ad_oe` is 1 and `ad_out` carries address bits 7:0. For memory cycles `addr_hi` carries address bits 15:8 from T1 to the last T-state. `ale` is high for exactly one cycle.
- R3: `req_kind` codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. The status {`s1`,`s0`} is 11 for a fetch, 10 for a read, 01 for a write and 00 when no cycle runs. `io_m` is 1 for I/O cycles and 0 otherwise. Both hold steady from T1 to the last T-state.
- R4: With `bus_ready` high, an opcode fetch lasts four T-states, and its fourth state (T4) has both strobes high and `ad_oe`=0. The other four kinds last three T-states. `req_ready` is 1 again in the cycle after the last T-state.
- R5: In read-type cycles (kinds 0, 1 and 3), `rd_n` is 0 in T2, in every wait state and in T3, and `ad_oe` is 0 then. The byte on `ad_in` at the clock edge that ends T3 appears on `rdata`, and `done` is 1 for exactly the following cycle.
- R6: In write-type cycles (kinds 2 and 4), `wr_n` is 0 from T2 through T3 with `ad_oe`=1 and `ad_out` carrying the write byte. `rd_n` stays 1 and `done` stays 0.
- R7: In I/O cycles the port number (address bits 7:0) appears on `ad_out` in T1 and also on `addr_hi`.
- R8: `bus_ready` is sampled at the edge that ends T2 and at the edge that ends each wait state. Every low sample adds one wait state, during which the strobe, status and data outputs keep their T2 values.
- R9: When `hold` is high, the bus is handed over at the first edge where no cycle is in flight or the last T-state ends. From the next cycle `hlda` is 1, `bus_oe` is 0, `ad_oe` is 0, `ale` is 0 and `req_ready` is 0. No request is taken while the bus is handed over. A cycle under way when `hold` rises keeps `hlda` at 0 until it has finished.
- R10: After `hold` falls, `hlda` returns to 0 and `bus_oe` to 1 in the next cycle, and requests are taken again.
- R11: A request with `req_kind` 5, 6 or 7 is ignored: `ale` stays 0, both strobes stay 1 and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address (port number in bits 7:0 for I/O) |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Sequencer will take a request at the next edge |
| bus_ready | input | 1 | Target ready; low inserts wait states |
| hold | input | 1 | Another master asks for the bus |
| hlda | output | 1 | Bus handed over |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared lines, driven value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_in | input | 8 | Shared lines, received value |
| ale | output | 1 | Address strobe in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| bus_oe | output | 1 | Enable for addr_hi, rd_n, wr_n, io_m |
| done | output | 1 | Read byte captured (one cycle) |
| rdata | output | 8 | Captured read byte |

## Verification
A T-state register that skips or repeats a state shows at once as a wrong strobe or a wrong `ale` in the next cycle. A missing or extra wait state shifts the `rd_n`/`wr_n` edge and the `done` pulse by one clock. A latched request field that is wrong shows as a bad status code, a bad `addr_hi` or a bad byte on `ad_out` from T1 onward. A fault in hold handling shows as `hlda` rising in mid-cycle or as outputs still enabled in the first cycle after the grant.

// File: rtl/bus_seq_pkg.sv
// Shared types and kind decoders for the multiplexed bus cycle sequencer.
// Assumes a 3-bit kind code; codes above 4 are illegal.
package bus_seq_pkg;

    typedef enum logic [2:0] {
        CYC_FETCH = 3'd0,
        CYC_MRD   = 3'd1,
        CYC_MWR   = 3'd2,
        CYC_IORD  = 3'd3,
        CYC_IOWR  = 3'd4
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } tstate_e;

    function automatic logic kind_legal(input logic [2:0] k);
        return k <= 3'd4;
    endfunction

    function automatic logic kind_reads(input cyc_kind_e k);
        return (k == CYC_FETCH) || (k == CYC_MRD) || (k == CYC_IORD);
    endfunction

    function automatic logic kind_writes(input cyc_kind_e k);
        return (k == CYC_MWR) || (k == CYC_IOWR);
    endfunction

    function automatic logic kind_is_io(input cyc_kind_e k);
        return (k == CYC_IORD) || (k == CYC_IOWR);
    endfunction

    function automatic logic [1:0] kind_status(input cyc_kind_e k);
        logic [1:0] code;
        case (k)
            CYC_FETCH:         code = 2'b11;
            CYC_MRD, CYC_IORD: code = 2'b10;
            CYC_MWR, CYC_IOWR: code = 2'b01;
            default:           code = 2'b00;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
// T-state sequencer. Takes a legal request only when idle and not
// handing over the bus, and inserts waits while bus_ready is low after T2.
// A fetch adds T4. The bus is granted only between machine cycles.
// Assumes the latched kind (is_fetch) is stable from T1 onward.
module bus_seq_fsm
    import bus_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       is_fetch,
    input  logic       hold,
    input  logic       bus_ready,
    output tstate_e    state,
    output logic       accept,
    output logic       req_ready
);

    tstate_e nxt;

    // Next T-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (hold)                                   nxt = ST_HOLD;
                else if (req_valid && kind_legal(req_kind)) nxt = ST_T1;
            end
            ST_T1:        nxt = ST_T2;
            ST_T2, ST_TW: nxt = bus_ready ? ST_T3 : ST_TW;
            ST_T3: begin
                if (is_fetch) nxt = ST_T4;
                else          nxt = hold ? ST_HOLD : ST_IDLE;
            end
            ST_T4:        nxt = hold ? ST_HOLD : ST_IDLE;
            ST_HOLD:      nxt = hold ? ST_HOLD : ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Request handshake terms.
    always_comb begin
        req_ready = (state == ST_IDLE) && !hold;
        accept    = req_ready && req_valid && kind_legal(req_kind);
    end

endmodule

// File: rtl/bus_seq_reqreg.sv
// Holds the accepted request so that status, address and write byte
// stay steady for the whole machine cycle. Loads only on accept.
module bus_seq_reqreg
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output cyc_kind_e         kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= CYC_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            kind_q  <= cyc_kind_e'(req_kind);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/bus_seq_drive.sv
// Decodes the T-state and the latched request into bus pin values.
// Pure combinational. An I/O cycle repeats the port byte on the high
// address lines. During hand-over every enable is dropped except ale.
module bus_seq_drive
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int HI_W   = ADDR_W - DATA_W
) (
    input  tstate_e           state,
    input  cyc_kind_e         kind_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              s1,
    output logic              s0,
    output logic              bus_oe,
    output logic              hlda
);

    logic in_cycle;
    logic strobe;

    // Phase terms.
    always_comb begin
        in_cycle = (state == ST_T1) || (state == ST_T2) || (state == ST_TW) ||
                   (state == ST_T3) || (state == ST_T4);
        strobe   = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    end

    // Strobes, status and enables.
    always_comb begin
        ale      = (state == ST_T1);
        rd_n     = !(strobe && kind_reads(kind_q));
        wr_n     = !(strobe && kind_writes(kind_q));
        ad_oe    = (state == ST_T1) || (strobe && kind_writes(kind_q));
        ad_out   = (state == ST_T1) ? addr_q[DATA_W-1:0] : wdata_q;
        {s1, s0} = in_cycle ? kind_status(kind_q) : 2'b00;
        io_m     = in_cycle && kind_is_io(kind_q);
        bus_oe   = (state != ST_HOLD);
        hlda     = (state == ST_HOLD);
    end

    // High address byte: port byte repeated for I/O, upper address otherwise.
    always_comb begin
        for (int i = 0; i < HI_W; i++) begin
            if (kind_is_io(kind_q)) addr_hi[i] = addr_q[i % DATA_W];
            else                    addr_hi[i] = addr_q[DATA_W + i];
        end
    end

endmodule

// File: rtl/bus_seq_capture.sv
// Samples the shared lines at the edge that ends T3 of a read-type
// cycle and raises done for the one following cycle.
module bus_seq_capture
    import bus_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tstate_e           state,
    input  cyc_kind_e         kind_q,
    input  logic [DATA_W-1:0] ad_in,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    logic take;

    // Capture condition.
    always_comb take = (state == ST_T3) && kind_reads(kind_q);

    // Read byte register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= take;
            if (take) rdata <= ad_in;
        end
    end

endmodule

// File: rtl/bus_seq_top.sv
// Multiplexed address/data bus cycle sequencer: runs one machine cycle
// per accepted request, with READY waits and HOLD hand-over.
// Assumes ADDR_W > DATA_W; the shared lines carry the low DATA_W bits.
module bus_seq_top
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    input  logic                     bus_ready,
    input  logic                     hold,
    output logic                     hlda,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic                     bus_oe,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata
);

    localparam int HI_W = ADDR_W - DATA_W;

    tstate_e           state;
    logic              accept;
    cyc_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    bus_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .is_fetch  (kind_q == CYC_FETCH),
        .hold      (hold),
        .bus_ready (bus_ready),
        .state     (state),
        .accept    (accept),
        .req_ready (req_ready)
    );

    bus_seq_reqreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q)
    );

    bus_seq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_W(HI_W)) u_drv (
        .state   (state),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .addr_hi (addr_hi),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .io_m    (io_m),
        .s1      (s1),
        .s0      (s0),
        .bus_oe  (bus_oe),
        .hlda    (hlda)
    );

    bus_seq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .kind_q (kind_q),
        .ad_in  (ad_in),
        .done   (done),
        .rdata  (rdata)
    );

endmodule

// File: rtl/bus_seq_checker.sv
// Port-level protocol checks for bus_seq_top, attached by bind.
module bus_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_ready,
    input logic hold,
    input logic hlda,
    input logic ad_oe,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic io_m,
    input logic s1,
    input logic s0,
    input logic bus_oe,
    input logic done
);

    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r2_ale_drives_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && bus_oe));

    a_r3_status_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ((s1 || s0) && !ale) |-> $stable({s1, s0, io_m}));

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r5_read_floats_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_write_drives_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    a_r8_wait_keeps_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) && !bus_ready) |=> !rd_n);

    a_r9_handover_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!bus_oe && !ad_oe && rd_n && wr_n && !ale));

    a_r9_grant_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(hold));

    a_r10_release_needs_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda) |-> $past(!hold));

endmodule

bind bus_seq_top bus_seq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ready (bus_ready),
    .hold      (hold),
    .hlda      (hlda),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m),
    .s1        (s1),
    .s0        (s0),
    .bus_oe    (bus_oe),
    .done      (done)
);

// File: tb/tb_bus_seq_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected pin values for each
// future cycle; a monitor compares them at the falling edge.
module tb_bus_seq_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [2:0] req_kind;
    logic [15:0] req_addr;
    logic [7:0] req_wdata;
    logic       req_ready;
    logic       bus_ready;
    logic       hold;
    logic       hlda;
    logic [7:0] addr_hi;
    logic [7:0] ad_out;
    logic       ad_oe;
    logic [7:0] ad_in;
    logic       ale, rd_n, wr_n, io_m, s1, s0, bus_oe, done;
    logic [7:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int unsigned cyc = 0;

    typedef struct {
        int unsigned cyc;
        string       tag;
        logic        ale, rd_n, wr_n, ad_oe;
        logic        chk_ad;
        logic [7:0]  ad;
        logic        chk_hi;
        logic [7:0]  hi;
        logic [1:0]  st;
        logic        io_m, done;
        logic        chk_rd;
        logic [7:0]  rd;
        logic        hlda, bus_oe, rq;
    } exp_t;

    exp_t q[$];

    bus_seq_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .bus_ready(bus_ready), .hold(hold), .hlda(hlda), .addr_hi(addr_hi),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0), .bus_oe(bus_oe),
        .done(done), .rdata(rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t idle_item(input int unsigned c, input string tag);
        exp_t e;
        e.cyc = c; e.tag = tag;
        e.ale = 0; e.rd_n = 1; e.wr_n = 1; e.ad_oe = 0;
        e.chk_ad = 0; e.ad = 0; e.chk_hi = 0; e.hi = 0;
        e.st = 2'b00; e.io_m = 0; e.done = 0; e.chk_rd = 0; e.rd = 0;
        e.hlda = 0; e.bus_oe = 1; e.rq = 1;
        return e;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    // Monitor: compare queued expectations for the current cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                logic ok;
                e = q.pop_front();
                n_checks++;
                ok = (e.cyc == cyc) && ale === e.ale && rd_n === e.rd_n &&
                     wr_n === e.wr_n && ad_oe === e.ad_oe &&
                     (!e.chk_ad || ad_out === e.ad) && (!e.chk_hi || addr_hi === e.hi) &&
                     {s1, s0} === e.st && io_m === e.io_m && done === e.done &&
                     (!e.chk_rd || rdata === e.rd) && hlda === e.hlda &&
                     bus_oe === e.bus_oe && req_ready === e.rq;
                if (!ok) begin
                    n_fail++;
                    $display("FAIL %s at cycle %0d (item cycle %0d): actual ale=%b rd_n=%b wr_n=%b oe=%b ad=%h hi=%h st=%b io=%b done=%b rdata=%h hlda=%b bus_oe=%b rq=%b expected ale=%b rd_n=%b wr_n=%b oe=%b ad=%h hi=%h st=%b io=%b done=%b rdata=%h hlda=%b bus_oe=%b rq=%b",
                             e.tag, cyc, e.cyc, ale, rd_n, wr_n, ad_oe, ad_out, addr_hi,
                             {s1, s0}, io_m, done, rdata, hlda, bus_oe, req_ready,
                             e.ale, e.rd_n, e.wr_n, e.ad_oe, e.ad, e.hi, e.st, e.io_m,
                             e.done, e.rd, e.hlda, e.bus_oe, e.rq);
                end
            end
        end
    end

    // Driver: one machine cycle, entered and left at a falling edge while idle.
    task automatic run_cycle(input logic [2:0] kind, input logic [15:0] addr,
                             input logic [7:0] wd, input logic [7:0] rb,
                             input int nw, input bit hold_mid);
        int unsigned c;
        int unsigned p;
        logic rdk, wrk, iok, fetch;
        logic [1:0] st;
        logic [7:0] hi;
        exp_t e;
        c     = cyc;
        fetch = (kind == 3'd0);
        rdk   = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd3);
        wrk   = (kind == 3'd2) || (kind == 3'd4);
        iok   = (kind == 3'd3) || (kind == 3'd4);
        st    = fetch ? 2'b11 : (rdk ? 2'b10 : 2'b01);
        hi    = iok ? addr[7:0] : addr[15:8];
        // T1: address strobe, low byte on shared lines (R2, R7 for I/O)
        e = idle_item(c + 1, iok ? "R7" : "R2");
        e.ale = 1; e.ad_oe = 1; e.chk_ad = 1; e.ad = addr[7:0];
        e.chk_hi = 1; e.hi = hi; e.st = st; e.io_m = iok; e.rq = 0;
        q.push_back(e);
        // T2, waits, T3 (R5 read, R6 write, R8 waits, R3 status steady)
        for (int k = 0; k <= nw + 1; k++) begin
            e = idle_item(c + 2 + k, (k == 0) ? (wrk ? "R6" : "R5") :
                                     ((k <= nw) ? "R8" : "R3"));
            e.rd_n = !rdk; e.wr_n = !wrk; e.ad_oe = wrk; e.chk_ad = wrk; e.ad = wd;
            e.chk_hi = 1; e.hi = hi; e.st = st; e.io_m = iok; e.rq = 0;
            q.push_back(e);
        end
        if (fetch) begin
            // T4 of a fetch (R4), with the done pulse (R5)
            e = idle_item(c + 4 + nw, "R4");
            e.chk_hi = 1; e.hi = hi; e.st = st; e.rq = 0;
            e.done = 1; e.chk_rd = 1; e.rd = rb;
            q.push_back(e);
        end
        p = c + 4 + nw + (fetch ? 1 : 0);
        e = idle_item(p, hold_mid ? "R9" : (rdk ? "R5" : "R4"));
        e.done = rdk && !fetch;
        e.chk_rd = rdk; e.rd = rb;
        if (hold_mid) begin
            e.hlda = 1; e.bus_oe = 0; e.rq = 0;
        end
        q.push_back(e);
        req_valid = 1; req_kind = kind; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0; req_addr = 16'hDEAD; req_wdata = 8'h00;
        bus_ready = (nw == 0); ad_in = rb;
        if (hold_mid) hold = 1;
        repeat (1 + nw) @(negedge clk);
        bus_ready = 1;
        while (cyc <= p) @(negedge clk);
    endtask

    // Driver: release a pending hold and expect the bus back (R10).
    task automatic release_hold();
        hold = 0;
        q.push_back(idle_item(cyc + 1, "R10"));
        repeat (2) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_kind = 0; req_addr = 0; req_wdata = 0;
        bus_ready = 1; hold = 0; ad_in = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", {ale, rd_n, wr_n, ad_oe, hlda, done, bus_oe, s1, s0, io_m, req_ready},
                    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1});

        run_cycle(3'd0, 16'h1234, 8'h00, 8'hA5, 0, 0);  // fetch (R4)
        run_cycle(3'd1, 16'h8001, 8'h00, 8'h3C, 0, 0);  // memory read
        run_cycle(3'd2, 16'h4055, 8'h7E, 8'h00, 0, 0);  // memory write
        run_cycle(3'd3, 16'h119C, 8'h00, 8'h81, 0, 0);  // I/O read
        run_cycle(3'd4, 16'hF042, 8'hC3, 8'h00, 0, 0);  // I/O write
        run_cycle(3'd1, 16'h2468, 8'h00, 8'h5A, 2, 0);  // read with waits (R8)
        run_cycle(3'd0, 16'hFFFE, 8'h00, 8'h0F, 1, 0);  // fetch with a wait
        run_cycle(3'd4, 16'h0077, 8'h99, 8'h00, 3, 0);  // I/O write with waits

        // R11: illegal kinds are ignored
        for (int k = 5; k <= 7; k++) begin
            req_valid = 1; req_kind = 3'(k); req_addr = 16'h5555;
            q.push_back(idle_item(cyc + 1, "R11"));
            q.push_back(idle_item(cyc + 2, "R11"));
            repeat (2) @(negedge clk);
            req_valid = 0;
            @(negedge clk);
        end

        // R9: hold while idle; a pending request is not taken
        hold = 1; req_valid = 1; req_kind = 3'd1; req_addr = 16'h3333;
        for (int k = 1; k <= 3; k++) begin
            exp_t e;
            e = idle_item(cyc + k, "R9");
            e.hlda = 1; e.bus_oe = 0; e.rq = 0;
            q.push_back(e);
        end
        repeat (3) @(negedge clk);
        req_valid = 0;
        release_hold();

        // R9: hold raised mid-cycle is granted only after the cycle ends
        run_cycle(3'd2, 16'hABCD, 8'h6B, 8'h00, 1, 1);
        release_hold();
        run_cycle(3'd1, 16'h0102, 8'h00, 8'hE7, 0, 0);  // R10: bus back in use
        run_cycle(3'd0, 16'h0200, 8'h00, 8'h18, 0, 1);  // hold during a fetch
        release_hold();

        repeat (2) @(negedge clk);
        check("R4", 64'(q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule